// File: doc/BRIEF.md
# Hysteretic Threshold Gate Set for Dual-Rail Logic

This block collects the state-holding threshold gates that a delay-insensitive, dual-rail datapath is built from. It contains four gates. The first is a generic m-of-n gate whose input count and threshold are parameters. The second is a two-input gate that needs both inputs high. The third is a complemented 2-of-4 gate that works on two input pairs. The fourth is a dual-rail XOR made from two of the 2-of-4 gates. Each gate drives its output high as soon as its set condition holds. The output then stays high until every input of that gate has dropped to zero, which is the empty (NULL) wavefront between two data wavefronts.

The hold behaviour is modelled with one state bit per gate, and each bit is clocked by a fast sampling clock. A gate output is combinational: it is the set condition ORed with the held bit, where the held bit is masked once all inputs are low. The state bit takes the output value at every rising clock edge. This keeps every gate synthesizable and makes each gate's behaviour depend only on its inputs and the value held at the most recent edge.

Top module: `ncl_gate_set`

## Requirements
- R1: While `rst_ni` is low, every held state is cleared at once. Each output then equals only its set condition, so a gate that was holding high with its inputs below the set condition reads 0.
- R2: With a cleared held state, `thmn_o` is 1 exactly when at least GEN_THRESH of the GEN_INPUTS bits of `thmn_in_i` are 1. GEN_THRESH must satisfy 1 <= GEN_THRESH <= GEN_INPUTS.
- R3: Once `thmn_o` has been captured high at a clock edge, it stays 1 for any input pattern that has at least one bit set.
- R4: `thmn_o` is 0 whenever `thmn_in_i` is all zeros, whatever the held state.
- R5: `th22_o` sets when both `th22_a_i` and `th22_b_i` are 1. It holds while either input is 1 and clears when both are 0.
- R6: `comp_o` sets when (`comp_a_i` or `comp_b_i`) and (`comp_c_i` or `comp_d_i`) are true. It holds while any of the four inputs is 1 and clears when all four are 0.
- R7: Dual-rail operands use true rail 1 for data 1, false rail 1 for data 0, and both rails 0 for NULL. For data operands, `xor_t_o` is 1 when the two values differ and `xor_f_o` is 1 when they match. With both operands NULL, both output rails are 0. The two output rails are never 1 together while inputs go through NULL between data.
- R8: After data has set an XOR rail, that rail stays set while one operand has returned to NULL and the other still carries data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the held state bits |
| rst_ni | input | 1 | Active-low asynchronous reset of all held states |
| thmn_in_i | input | GEN_INPUTS | Inputs of the generic m-of-n gate |
| thmn_o | output | 1 | Output of the generic m-of-n gate |
| th22_a_i | input | 1 | First input of the two-of-two gate |
| th22_b_i | input | 1 | Second input of the two-of-two gate |
| th22_o | output | 1 | Output of the two-of-two gate |
| comp_a_i | input | 1 | First pair, input A |
| comp_b_i | input | 1 | First pair, input B |
| comp_c_i | input | 1 | Second pair, input C |
| comp_d_i | input | 1 | Second pair, input D |
| comp_o | output | 1 | Output of the complemented 2-of-4 gate |
| xa_t_i | input | 1 | Operand A, true rail |
| xa_f_i | input | 1 | Operand A, false rail |
| xb_t_i | input | 1 | Operand B, true rail |
| xb_f_i | input | 1 | Operand B, false rail |
| xor_t_o | output | 1 | XOR result, true rail |
| xor_f_o | output | 1 | XOR result, false rail |

## Verification
The set condition and the NULL clear act in the same cycle as the input change, because every output is combinational over the inputs and the held bit. The held bit only reflects an output value after the next rising clock edge. The bench therefore drives inputs on the falling edge and samples one nanosecond later, before any rising edge. To prepare a held state of 1 or 0, it drives all ones or all zeros across exactly one rising edge and then applies the pattern under test. Reset clears the held bits asynchronously, so the reset check is sampled while reset is still low, with no clock edge in between.

// File: rtl/ncl_gate_pkg.sv
`timescale 1ns/1ps
package ncl_gate_pkg;
  localparam int unsigned MAX_GATE_INPUTS = 32;

  function automatic int unsigned count_ones(input logic [MAX_GATE_INPUTS-1:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < MAX_GATE_INPUTS; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/ncl_hyst_cell.sv
`timescale 1ns/1ps
// Shared hold element: set wins, NULL releases, else keep sampled value.
module ncl_hyst_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic null_i,
  output logic out_o
);
  logic held_q;

  assign out_o = set_i | (held_q & ~null_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else         held_q <= out_o;
  end
endmodule

// File: rtl/ncl_thmn_gate.sv
`timescale 1ns/1ps
module ncl_thmn_gate #(
  parameter int unsigned N = 4,
  parameter int unsigned M = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  import ncl_gate_pkg::*;

  logic set_w;
  logic null_w;

  assign null_w = ~|in_i;

  // Cheap forms for the OR and AND corners, counter otherwise.
  generate
    if (M == 1) begin : g_any
      assign set_w = |in_i;
    end else if (M == N) begin : g_all
      assign set_w = &in_i;
    end else begin : g_cnt
      logic [MAX_GATE_INPUTS-1:0] ext_w;
      assign ext_w = MAX_GATE_INPUTS'(in_i);
      assign set_w = (count_ones(ext_w) >= M);
    end
  endgenerate

  ncl_hyst_cell hold_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .null_i (null_w),
    .out_o  (out_o)
  );
endmodule

// File: rtl/ncl_th24comp_gate.sv
`timescale 1ns/1ps
module ncl_th24comp_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  output logic out_o
);
  logic set_w;
  logic null_w;

  assign set_w  = (a_i | b_i) & (c_i | d_i);
  assign null_w = ~(a_i | b_i | c_i | d_i);

  ncl_hyst_cell hold_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_w),
    .null_i (null_w),
    .out_o  (out_o)
  );
endmodule

// File: rtl/ncl_dr_xor.sv
`timescale 1ns/1ps
// Dual-rail XOR from two complemented 2-of-4 gates.
module ncl_dr_xor (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_t_i,
  input  logic a_f_i,
  input  logic b_t_i,
  input  logic b_f_i,
  output logic z_t_o,
  output logic z_f_o
);
  // (at|bt)&(af|bf) -> operands differ
  ncl_th24comp_gate true_rail_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .a_i (a_t_i), .b_i (b_t_i), .c_i (a_f_i), .d_i (b_f_i),
    .out_o (z_t_o)
  );

  // (at|bf)&(af|bt) -> operands match
  ncl_th24comp_gate false_rail_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .a_i (a_t_i), .b_i (b_f_i), .c_i (a_f_i), .d_i (b_t_i),
    .out_o (z_f_o)
  );
endmodule

// File: rtl/ncl_gate_set.sv
`timescale 1ns/1ps
module ncl_gate_set #(
  parameter int unsigned GEN_INPUTS = 4,
  parameter int unsigned GEN_THRESH = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [GEN_INPUTS-1:0] thmn_in_i,
  output logic                  thmn_o,
  input  logic                  th22_a_i,
  input  logic                  th22_b_i,
  output logic                  th22_o,
  input  logic                  comp_a_i,
  input  logic                  comp_b_i,
  input  logic                  comp_c_i,
  input  logic                  comp_d_i,
  output logic                  comp_o,
  input  logic                  xa_t_i,
  input  logic                  xa_f_i,
  input  logic                  xb_t_i,
  input  logic                  xb_f_i,
  output logic                  xor_t_o,
  output logic                  xor_f_o
);
  ncl_thmn_gate #(.N(GEN_INPUTS), .M(GEN_THRESH)) gen_gate_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .in_i (thmn_in_i), .out_o (thmn_o)
  );

  ncl_thmn_gate #(.N(2), .M(2)) th22_gate_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .in_i ({th22_b_i, th22_a_i}), .out_o (th22_o)
  );

  ncl_th24comp_gate comp_gate_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .a_i (comp_a_i), .b_i (comp_b_i), .c_i (comp_c_i), .d_i (comp_d_i),
    .out_o (comp_o)
  );

  ncl_dr_xor xor_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .a_t_i (xa_t_i), .a_f_i (xa_f_i), .b_t_i (xb_t_i), .b_f_i (xb_f_i),
    .z_t_o (xor_t_o), .z_f_o (xor_f_o)
  );
endmodule

// File: rtl/ncl_gate_set_chk.sv
`timescale 1ns/1ps
module ncl_gate_set_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned M = 3
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] thmn_in_i,
  input logic         thmn_o,
  input logic         th22_a_i,
  input logic         th22_b_i,
  input logic         th22_o,
  input logic         comp_a_i,
  input logic         comp_b_i,
  input logic         comp_c_i,
  input logic         comp_d_i,
  input logic         comp_o,
  input logic         xor_t_o,
  input logic         xor_f_o
);
  AST_GEN_SETS_AT_THRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(thmn_in_i) >= M) |-> thmn_o);  // R2

  AST_GEN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(thmn_o) && (thmn_in_i != '0)) |-> thmn_o);  // R3

  AST_GEN_NULL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thmn_in_i == '0) |-> !thmn_o);  // R4

  AST_TH22_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (th22_a_i && th22_b_i) |-> th22_o);  // R5

  AST_TH22_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(th22_o) && (th22_a_i || th22_b_i)) |-> th22_o);  // R5

  AST_COMP_NULL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(comp_a_i || comp_b_i || comp_c_i || comp_d_i) |-> !comp_o);  // R6

  AST_XOR_RAILS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xor_t_o && xor_f_o));  // R7
endmodule

bind ncl_gate_set ncl_gate_set_chk #(.N(GEN_INPUTS), .M(GEN_THRESH)) chk_i (
  .clk_i (clk_i), .rst_ni (rst_ni), .thmn_in_i (thmn_in_i), .thmn_o (thmn_o),
  .th22_a_i (th22_a_i), .th22_b_i (th22_b_i), .th22_o (th22_o),
  .comp_a_i (comp_a_i), .comp_b_i (comp_b_i), .comp_c_i (comp_c_i),
  .comp_d_i (comp_d_i), .comp_o (comp_o),
  .xor_t_o (xor_t_o), .xor_f_o (xor_f_o)
);

// File: tb/ncl_gate_set_tb_top.sv
`timescale 1ns/1ps
module ncl_gate_set_tb_top;
  localparam int unsigned N = 4;
  localparam int unsigned M = 3;

  // {a_t, a_f, b_t, b_f, exp_z_t, exp_z_f}
  localparam logic [5:0] XOR_VEC [10] = '{
    6'b01_01_01,  // 0 ^ 0
    6'b00_00_00,  // NULL
    6'b01_10_10,  // 0 ^ 1
    6'b00_00_00,
    6'b10_01_10,  // 1 ^ 0
    6'b00_01_10,  // A NULL, B still data: hold
    6'b00_00_00,
    6'b10_10_01,  // 1 ^ 1
    6'b10_00_01,  // B NULL, A still data: hold
    6'b00_00_00
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] thmn_in_i = '0;
  logic th22_a_i = 0, th22_b_i = 0;
  logic comp_a_i = 0, comp_b_i = 0, comp_c_i = 0, comp_d_i = 0;
  logic xa_t_i = 0, xa_f_i = 0, xb_t_i = 0, xb_f_i = 0;
  logic thmn_o, th22_o, comp_o, xor_t_o, xor_f_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  ncl_gate_set #(.GEN_INPUTS(N), .GEN_THRESH(M)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .thmn_in_i (thmn_in_i), .thmn_o (thmn_o),
    .th22_a_i (th22_a_i), .th22_b_i (th22_b_i), .th22_o (th22_o),
    .comp_a_i (comp_a_i), .comp_b_i (comp_b_i), .comp_c_i (comp_c_i),
    .comp_d_i (comp_d_i), .comp_o (comp_o),
    .xa_t_i (xa_t_i), .xa_f_i (xa_f_i), .xb_t_i (xb_t_i), .xb_f_i (xb_f_i),
    .xor_t_o (xor_t_o), .xor_f_o (xor_f_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Pass one rising edge, return at the falling edge.
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: outputs low in reset with NULL inputs
    @(negedge clk_i);
    settle();
    check("R1 reset gen", thmn_o, 1'b0);
    check("R1 reset th22", th22_o, 1'b0);
    check("R1 reset xor_t", xor_t_o, 1'b0);
    check("R1 reset xor_f", xor_f_o, 1'b0);
    rst_ni = 1'b1;
    step();

    // R2: held 0, every pattern; R3/R4: held 1, every pattern
    for (int p = 0; p < (1 << N); p++) begin
      thmn_in_i = '0;
      step();
      thmn_in_i = N'(p);
      settle();
      check("R2 gen from held 0", thmn_o, ($countones(N'(p)) >= M));
      @(negedge clk_i);
      thmn_in_i = '1;
      step();
      thmn_in_i = N'(p);
      settle();
      if (p == 0) check("R4 gen NULL from held 1", thmn_o, 1'b0);
      else        check("R3 gen hold from held 1", thmn_o, 1'b1);
      @(negedge clk_i);
    end
    thmn_in_i = '0;
    step();

    // R5: two-of-two
    th22_a_i = 1; settle(); check("R5 th22 one input", th22_o, 1'b0);
    @(negedge clk_i);
    th22_b_i = 1; settle(); check("R5 th22 both set", th22_o, 1'b1);
    step();
    th22_a_i = 0; settle(); check("R5 th22 hold", th22_o, 1'b1);
    step();
    th22_b_i = 0; settle(); check("R5 th22 clear", th22_o, 1'b0);
    step();
    th22_b_i = 1; settle(); check("R5 th22 no reset from one", th22_o, 1'b0);
    th22_b_i = 0;
    step();

    // R6: complemented 2-of-4
    comp_a_i = 1; comp_b_i = 1; settle();
    check("R6 comp one pair", comp_o, 1'b0);
    @(negedge clk_i);
    comp_d_i = 1; settle(); check("R6 comp set", comp_o, 1'b1);
    step();
    comp_a_i = 0; comp_b_i = 0; settle(); check("R6 comp hold", comp_o, 1'b1);
    step();
    comp_d_i = 0; settle(); check("R6 comp clear", comp_o, 1'b0);
    step();
    comp_c_i = 1; comp_d_i = 1; settle();
    check("R6 comp second pair only", comp_o, 1'b0);
    comp_c_i = 0; comp_d_i = 0;
    step();

    // R7/R8: dual-rail XOR table
    foreach (XOR_VEC[i]) begin
      {xa_t_i, xa_f_i, xb_t_i, xb_f_i} = XOR_VEC[i][5:2];
      settle();
      check((i == 5 || i == 8) ? "R8 xor_t hold" : "R7 xor_t", xor_t_o, XOR_VEC[i][1]);
      check((i == 5 || i == 8) ? "R8 xor_f hold" : "R7 xor_f", xor_f_o, XOR_VEC[i][0]);
      step();
    end

    // R1: reset drops a held output immediately
    thmn_in_i = '1; th22_a_i = 1; th22_b_i = 1;
    step();
    thmn_in_i = N'(1); th22_b_i = 0;
    settle();
    check("R1 pre-reset gen hold", thmn_o, 1'b1);
    rst_ni = 1'b0;
    settle();
    check("R1 reset clears gen", thmn_o, 1'b0);
    check("R1 reset clears th22", th22_o, 1'b0);
    thmn_in_i = '0; th22_a_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule